// File: doc/BRIEF.md
# Nonlinear Combiner with Rotational Diffusion

This block is the combining stage of a word-oriented stream generator. It takes eight 31-bit cells of a shift register, forms four 32-bit words from their upper and lower 16-bit halves, and evaluates a nonlinear function. That function holds two 32-bit state words, R1 and R2. Each cycle it presents a 32-bit result W and the fourth reorganized word X3. Both are combinational in the current cells and state.

On a step strobe, R1 and R2 are replaced. Each new value is formed by crossing halves of two intermediate words, applying one of two rotate-and-XOR diffusions, and passing every byte through an 8-bit substitution table. The tables live outside the block and are reached through eight combinational lookup ports. A controller outside the block decides when R1 and R2 are cleared and when they advance.

Top module: `zcomb_core`

## Requirements
- R1: X0 is the upper half of cell 15 (bits 30 down to 15) above the lower half of cell 14 (bits 15 down to 0); with R1 = R2 = 0, `w_out` equals X0.
- R2: `x3_out` is the lower half of cell 2 (bits 15..0) above the upper half of cell 0 (bits 30..15), with no dependence on R1 or R2.
- R3: `w_out` = (X0 XOR R1) + R2 modulo 2^32, with any carry out of bit 31 dropped.
- R4: With W1 = R1 + X1 mod 2^32 and W2 = R2 XOR X2, lookup ports 0..3 receive L1(lower half of W1 above upper half of W2). L1 XORs its input with its 32-bit left rotations by 2, 10, 18 and 24. X1 is the lower half of cell 11 above the upper half of cell 9, and X2 is the lower half of cell 7 above the upper half of cell 5.
- R5: Lookup ports 4..7 receive L2(lower half of W2 above upper half of W1). L2 XORs its input with its left rotations by 8, 14, 22 and 30.
- R6: Lookup port p drives `sb_addr[8p+7:8p]` and reads `sb_data[8p+7:8p]`. Port 4g+k carries byte k (k=0 least significant) of the group-g word (g=0 for R1, g=1 for R2). The byte in that position must be looked up in table S0 when p is odd and in table S1 when p is even, so the most significant byte goes to S0. After a step, R1 = `sb_data[31:0]` and R2 = `sb_data[63:32]` as sampled at that edge.
- R7: With `clr` and `step` both low, R1 and R2 hold their values across clock edges.
- R8: `clr` high sets R1 and R2 to zero at the next edge and takes priority over `step`.
- R9: `rst_n` low clears R1 and R2 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of R1 and R2 |
| clr | input | 1 | Synchronous clear of R1 and R2 |
| step | input | 1 | Advance R1 and R2 at this edge |
| lfsr_c0 | input | 31 | Shift register cell 0 |
| lfsr_c2 | input | 31 | Shift register cell 2 |
| lfsr_c5 | input | 31 | Shift register cell 5 |
| lfsr_c7 | input | 31 | Shift register cell 7 |
| lfsr_c9 | input | 31 | Shift register cell 9 |
| lfsr_c11 | input | 31 | Shift register cell 11 |
| lfsr_c14 | input | 31 | Shift register cell 14 |
| lfsr_c15 | input | 31 | Shift register cell 15 |
| sb_data | input | 64 | Eight substitution results, one byte per lookup port |
| sb_addr | output | 64 | Eight substitution indices, one byte per lookup port |
| w_out | output | 32 | Combiner result W |
| x3_out | output | 32 | Fourth reorganized word X3 |

## Verification
The assertions assume that `sb_data` is a combinational function of `sb_addr` that settles within the cycle. The R1 and R2 load checks compare against the table bytes present at the stepping edge. The bench meets this by computing `sb_data` from `sb_addr` in a combinational process using two fixed byte bijections. It changes cells, `clr` and `step` only on falling edges. It releases reset on a falling edge, so no registered check spans a reset edge that is out of step with the clock.

// File: rtl/zcomb_pkg.sv
package zcomb_pkg;
   localparam int unsigned ZC_CELL_W = 31;
   localparam int unsigned ZC_HALF_W = 16;
   localparam int unsigned ZC_WORD_W = 32;
   localparam int unsigned ZC_BYTE_W = 8;
   localparam int unsigned ZC_NTAP   = 4;

   typedef int unsigned rot_list_t [ZC_NTAP];

   // rotation amounts of the two diffusion transforms
   localparam rot_list_t ZC_ROT_A = '{2, 10, 18, 24};
   localparam rot_list_t ZC_ROT_B = '{8, 14, 22, 30};
endpackage

// File: rtl/zcomb_reorg.sv
module zcomb_reorg #(
   parameter int unsigned CELL_W = 31,
   parameter int unsigned HALF_W = 16
) (
   input  logic [CELL_W-1:0]   c0,
   input  logic [CELL_W-1:0]   c2,
   input  logic [CELL_W-1:0]   c5,
   input  logic [CELL_W-1:0]   c7,
   input  logic [CELL_W-1:0]   c9,
   input  logic [CELL_W-1:0]   c11,
   input  logic [CELL_W-1:0]   c14,
   input  logic [CELL_W-1:0]   c15,
   output logic [2*HALF_W-1:0] x0,
   output logic [2*HALF_W-1:0] x1,
   output logic [2*HALF_W-1:0] x2,
   output logic [2*HALF_W-1:0] x3
);
   // upper half starts here; it overlaps the lower half by one bit
   localparam int unsigned HI_LSB = CELL_W - HALF_W;

   if (CELL_W <= HALF_W || CELL_W >= 2*HALF_W) begin : g_bad_width
      $error("zcomb_reorg: CELL_W must lie strictly between HALF_W and 2*HALF_W");
   end

   assign x0 = {c15[CELL_W-1:HI_LSB], c14[HALF_W-1:0]};
   assign x1 = {c11[HALF_W-1:0],      c9[CELL_W-1:HI_LSB]};
   assign x2 = {c7[HALF_W-1:0],       c5[CELL_W-1:HI_LSB]};
   assign x3 = {c2[HALF_W-1:0],       c0[CELL_W-1:HI_LSB]};

   logic unused_cells;
   assign unused_cells = ^{c15[HI_LSB-1:0], c14[CELL_W-1:HALF_W],
                           c11[CELL_W-1:HALF_W], c9[HI_LSB-1:0],
                           c7[CELL_W-1:HALF_W], c5[HI_LSB-1:0],
                           c2[CELL_W-1:HALF_W], c0[HI_LSB-1:0]};
endmodule

// File: rtl/zcomb_ldiff.sv
module zcomb_ldiff
   import zcomb_pkg::*;
#(
   parameter int unsigned WORD_W = ZC_WORD_W,
   parameter rot_list_t   ROT    = ZC_ROT_A
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   logic [WORD_W-1:0] term [ZC_NTAP];

   for (genvar g = 0; g < ZC_NTAP; g++) begin : g_tap
      if (ROT[g] == 0 || ROT[g] >= WORD_W) begin : g_bad
         $error("zcomb_ldiff: rotation amount out of range");
         assign term[g] = '0;
      end else begin : g_rot
         assign term[g] = {din[WORD_W-1-ROT[g]:0], din[WORD_W-1:WORD_W-ROT[g]]};
      end
   end

   always_comb begin
      dout = din;
      for (int i = 0; i < ZC_NTAP; i++) begin
         dout = dout ^ term[i];
      end
   end
endmodule

// File: rtl/zcomb_core.sv
module zcomb_core
   import zcomb_pkg::*;
#(
   parameter int unsigned CELL_W = ZC_CELL_W,
   parameter int unsigned HALF_W = ZC_HALF_W,
   parameter int unsigned WORD_W = ZC_WORD_W,
   parameter int unsigned BYTE_W = ZC_BYTE_W
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                clr,
   input  logic                                step,
   input  logic [CELL_W-1:0]                   lfsr_c0,
   input  logic [CELL_W-1:0]                   lfsr_c2,
   input  logic [CELL_W-1:0]                   lfsr_c5,
   input  logic [CELL_W-1:0]                   lfsr_c7,
   input  logic [CELL_W-1:0]                   lfsr_c9,
   input  logic [CELL_W-1:0]                   lfsr_c11,
   input  logic [CELL_W-1:0]                   lfsr_c14,
   input  logic [CELL_W-1:0]                   lfsr_c15,
   input  logic [2*WORD_W-1:0]                 sb_data,
   output logic [2*WORD_W-1:0]                 sb_addr,
   output logic [WORD_W-1:0]                   w_out,
   output logic [WORD_W-1:0]                   x3_out
);
   localparam int unsigned NLOOK = 2 * WORD_W / BYTE_W;

   if (WORD_W != 2*HALF_W) begin : g_bad_word
      $error("zcomb_core: WORD_W must be twice HALF_W");
   end
   if (WORD_W % BYTE_W != 0 || NLOOK != 8) begin : g_bad_byte
      $error("zcomb_core: word must split into four table bytes");
   end

   logic [WORD_W-1:0] r1_q, r2_q;
   logic [WORD_W-1:0] x0, x1, x2, x3;
   logic [WORD_W-1:0] w1, w2, mix1, mix2, dif1, dif2;

   zcomb_reorg #(.CELL_W(CELL_W), .HALF_W(HALF_W)) u_reorg (
      .c0(lfsr_c0), .c2(lfsr_c2), .c5(lfsr_c5), .c7(lfsr_c7),
      .c9(lfsr_c9), .c11(lfsr_c11), .c14(lfsr_c14), .c15(lfsr_c15),
      .x0(x0), .x1(x1), .x2(x2), .x3(x3)
   );

   assign w_out  = (x0 ^ r1_q) + r2_q;
   assign x3_out = x3;

   assign w1   = r1_q + x1;
   assign w2   = r2_q ^ x2;
   assign mix1 = {w1[HALF_W-1:0], w2[WORD_W-1:HALF_W]};
   assign mix2 = {w2[HALF_W-1:0], w1[WORD_W-1:HALF_W]};

   zcomb_ldiff #(.WORD_W(WORD_W), .ROT(ZC_ROT_A)) u_diff1 (.din(mix1), .dout(dif1));
   zcomb_ldiff #(.WORD_W(WORD_W), .ROT(ZC_ROT_B)) u_diff2 (.din(mix2), .dout(dif2));

   assign sb_addr = {dif2, dif1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r1_q <= '0;
         r2_q <= '0;
      end else if (clr) begin
         r1_q <= '0;
         r2_q <= '0;
      end else if (step) begin
         r1_q <= sb_data[WORD_W-1:0];
         r2_q <= sb_data[2*WORD_W-1:WORD_W];
      end
   end
endmodule

// File: rtl/zcomb_core_chk.sv
module zcomb_core_chk #(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned WORD_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic                 step,
   input logic [HALF_W-1:0]    c15_hi,
   input logic [HALF_W-1:0]    c14_lo,
   input logic [HALF_W-1:0]    c2_lo,
   input logic [HALF_W-1:0]    c0_hi,
   input logic [WORD_W-1:0]    r1_q,
   input logic [WORD_W-1:0]    r2_q,
   input logic [2*WORD_W-1:0]  sb_data,
   input logic [WORD_W-1:0]    w_out,
   input logic [WORD_W-1:0]    x3_out
);
   assert_x3_R2: assert property (@(posedge clk) disable iff (!rst_n)
      x3_out == {c2_lo, c0_hi});

   assert_w_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_out == (({c15_hi, c14_lo} ^ r1_q) + r2_q));

   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (r1_q == $past(sb_data[WORD_W-1:0])));

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (r2_q == $past(sb_data[2*WORD_W-1:WORD_W])));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> ($stable(r1_q) && $stable(r2_q)));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (r1_q == '0 && r2_q == '0));
endmodule

bind zcomb_core zcomb_core_chk #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
   .c15_hi(lfsr_c15[CELL_W-1:CELL_W-HALF_W]),
   .c14_lo(lfsr_c14[HALF_W-1:0]),
   .c2_lo(lfsr_c2[HALF_W-1:0]),
   .c0_hi(lfsr_c0[CELL_W-1:CELL_W-HALF_W]),
   .r1_q(r1_q), .r2_q(r2_q), .sb_data(sb_data),
   .w_out(w_out), .x3_out(x3_out)
);

// File: tb/tb_zcomb_core.sv
`timescale 1ns/1ps
module tb_zcomb_core;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, clr, step;
   logic [30:0] cur [16];
   logic [63:0] sb_data, sb_addr;
   logic [31:0] w_out, x3_out;

   int checks = 0;
   int errors = 0;

   zcomb_core dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
      .lfsr_c0(cur[0]), .lfsr_c2(cur[2]), .lfsr_c5(cur[5]), .lfsr_c7(cur[7]),
      .lfsr_c9(cur[9]), .lfsr_c11(cur[11]), .lfsr_c14(cur[14]), .lfsr_c15(cur[15]),
      .sb_data(sb_data), .sb_addr(sb_addr), .w_out(w_out), .x3_out(x3_out)
   );

   // reference tables: two fixed byte bijections
   function automatic logic [7:0] tab0(input logic [7:0] b);
      logic [7:0] t;
      t = b * 8'd29;
      return t + 8'h5b;
   endfunction
   function automatic logic [7:0] tab1(input logic [7:0] b);
      logic [7:0] t;
      t = (b ^ 8'hc3) * 8'd77;
      return t + 8'h11;
   endfunction

   always_comb begin
      for (int p = 0; p < 8; p++) begin
         sb_data[8*p +: 8] = (p % 2 == 1) ? tab0(sb_addr[8*p +: 8]) : tab1(sb_addr[8*p +: 8]);
      end
   end

   function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction
   function automatic logic [31:0] lin1(input logic [31:0] x);
      return x ^ rotl(x, 2) ^ rotl(x, 10) ^ rotl(x, 18) ^ rotl(x, 24);
   endfunction
   function automatic logic [31:0] lin2(input logic [31:0] x);
      return x ^ rotl(x, 8) ^ rotl(x, 14) ^ rotl(x, 22) ^ rotl(x, 30);
   endfunction
   function automatic logic [31:0] subw(input logic [31:0] x);
      return {tab0(x[31:24]), tab1(x[23:16]), tab0(x[15:8]), tab1(x[7:0])};
   endfunction
   function automatic logic [15:0] hi(input logic [30:0] c);
      return c[30:15];
   endfunction
   function automatic logic [15:0] lo(input logic [30:0] c);
      return c[15:0];
   endfunction

   // model state and scoreboard
   logic [31:0] r1m, r2m;
   logic [31:0] seed = 32'h1234_5678;
   logic [31:0] qw [$];
   logic [31:0] qx [$];
   logic [63:0] qa [$];
   string       qt [$];
   event        mon_ev;

   task automatic fill(input int mode);
      for (int i = 0; i < 16; i++) begin
         if (mode == 1) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            cur[i] = seed[30:0];
         end else if (mode == 2) begin
            cur[i] = 31'h0;
         end else if (mode == 3) begin
            cur[i] = 31'h7fff_ffff;
         end
      end
      if (mode == 2) begin
         cur[15] = 31'h4000_0000;
         cur[14] = 31'h0000_8001;
         cur[2]  = 31'h0001_a5c3;
         cur[0]  = 31'h2000_7fff;
      end
   endtask

   task automatic do_cycle(input int mode, input bit cl, input bit st, input string tag);
      logic [31:0] x0, x1, x2, x3, w1, w2, a1, a2;
      @(negedge clk);
      fill(mode);
      clr  = cl;
      step = st;
      x0 = {hi(cur[15]), lo(cur[14])};
      x1 = {lo(cur[11]), hi(cur[9])};
      x2 = {lo(cur[7]),  hi(cur[5])};
      x3 = {lo(cur[2]),  hi(cur[0])};
      w1 = r1m + x1;
      w2 = r2m ^ x2;
      a1 = lin1({w1[15:0], w2[31:16]});
      a2 = lin2({w2[15:0], w1[31:16]});
      qw.push_back((x0 ^ r1m) + r2m);
      qx.push_back(x3);
      qa.push_back({a2, a1});
      qt.push_back(tag);
      -> mon_ev;
      if (cl) begin
         r1m = '0;
         r2m = '0;
      end else if (st) begin
         r1m = subw(a1);
         r2m = subw(a2);
      end
   endtask

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per driven cycle
   initial begin
      forever begin
         @(mon_ev);
         #1;
         if (qw.size() != 0) begin
            chk(qt[0], "w_out",   {32'h0, w_out},  {32'h0, qw[0]});
            chk(qt[0], "x3_out",  {32'h0, x3_out}, {32'h0, qx[0]});
            chk(qt[0], "sb_addr", sb_addr,         qa[0]);
            void'(qw.pop_front());
            void'(qx.pop_front());
            void'(qa.pop_front());
            void'(qt.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      clr   = 1'b0;
      step  = 1'b0;
      r1m   = '0;
      r2m   = '0;
      for (int i = 0; i < 16; i++) cur[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      do_cycle(2, 0, 0, "R1");            // reset state: W equals X0
      do_cycle(2, 0, 1, "R2");            // X3 slicing, first step from zero
      do_cycle(1, 0, 1, "R4");
      do_cycle(1, 0, 1, "R5");
      do_cycle(3, 0, 1, "R3");            // all-ones cells with nonzero state
      do_cycle(3, 0, 0, "R3");
      for (int n = 0; n < 20; n++) do_cycle(1, 0, 1, "R6");
      do_cycle(1, 0, 0, "R7");
      do_cycle(0, 0, 0, "R7");
      do_cycle(1, 0, 0, "R7");
      do_cycle(1, 1, 1, "R8");            // clear wins over step
      do_cycle(0, 0, 0, "R8");
      for (int n = 0; n < 3; n++) do_cycle(1, 0, 1, "R4");

      @(negedge clk);
      rst_n = 1'b0;
      step  = 1'b0;
      r1m   = '0;
      r2m   = '0;
      #1;
      chk("R9", "w_out async", {32'h0, w_out},
          {32'h0, {hi(cur[15]), lo(cur[14])}});
      @(negedge clk);
      rst_n = 1'b1;
      do_cycle(0, 0, 0, "R9");

      do_cycle(1, 0, 1, "R5");
      do_cycle(1, 1, 0, "R8");
      do_cycle(1, 0, 0, "R8");

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule